// File: doc/BRIEF.md
# Programmable Interval Timer/Counter

This block is a 16-bit down-counter that a processor controls through a small byte-wide register window. Software loads a preload value one byte at a time, picks a mode, and then starts the count by reading a command address. An external tick-enable input sets the count rate: the counter moves by at most one step for each clock cycle in which the tick input is high.

In timer mode the counter reloads itself from the preload value each time it reaches its terminal count. At each reload it inverts a square-wave output, so the output period is twice the preload value in ticks. Once started, a timer cannot be halted, and the only way to stop it is a reset. In counter mode the count falls once per tick and wraps through zero. A stop command halts it. Both modes raise a sticky ready flag at terminal count. The stop command clears that flag, and an interrupt output passes the flag on when the interrupt enable is set.

Software reads the live count one byte at a time. Reading the low byte captures the upper byte at that moment, so a following read of the upper byte returns a value that matches the low byte already read.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset the block is stopped, in timer mode with the interrupt enable clear, the count and preload are all ones, and `sq_out`, `ready` and `irq` are 0. While stopped, ticks leave the count unchanged.
- R2: A write to address 0x4 sets the preload upper byte and a write to 0x5 sets its lower byte. Address 0x2 is the configuration register, with bit 0 for mode (0 timer, 1 counter) and bit 1 for interrupt enable. Reading 0x2 returns these two bits in the same positions.
- R3: A read at address 0xE loads the count from the preload and starts counting. This happens whether or not the block is already running. It takes priority over a tick in the same cycle.
- R4: In timer mode, a tick at a count of 1 or 0 reloads the preload, inverts `sq_out` and sets `ready`. Any other tick decrements the count. The output half-period is max(preload,1) ticks.
- R5: In timer mode a read at 0xF does not halt the count, and the square wave keeps toggling.
- R6: In counter mode each tick decrements the count, wrapping from 0 to all ones. A tick that takes the count from 1 to 0 sets `ready`, and `sq_out` never changes. A read at 0xF halts the count, and a tick in that same cycle is not applied.
- R7: A read at 0xF clears `ready` in either mode.
- R8: Configuration writes are ignored while the block is running and take effect while it is stopped.
- R9: `irq` is high exactly when `ready` is high and the interrupt enable bit is set.
- R10: `bus_rdata` is combinational on `bus_addr`. Address 0x7 returns the live low count byte, and a read there captures the upper byte. Address 0x6 returns the captured upper byte. Unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| sq_out | output | 1 | Square-wave output |
| ready | output | 1 | Sticky terminal-count flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count split into two 8-bit lanes and a 4-bit address. Small preload values such as 3 and 4 bring the terminal count and the reload within a few ticks. A preload of 0x0100 makes the upper byte change between a low-byte read and the following high-byte read, which exposes the capture behaviour. A reset partway through the run gives access to counter mode, because a started timer cannot otherwise be stopped.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
   typedef enum logic {
      MODE_TIMER   = 1'b0,
      MODE_COUNTER = 1'b1
   } pit_mode_e;

   typedef struct packed {
      logic      irq_en;
      pit_mode_e mode;
   } pit_cfg_t;
endpackage

// File: rtl/pit_cmd_decode.sv
`timescale 1ns/1ps
module pit_cmd_decode #(
   parameter int ADDR_W  = 4,
   parameter int A_CFG   = 2,
   parameter int A_START = 14,
   parameter int A_STOP  = 15
) (
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              start_cmd,
   output logic              stop_cmd,
   output logic              cfg_wr
);
   localparam logic [ADDR_W-1:0] AD_CFG   = ADDR_W'(A_CFG);
   localparam logic [ADDR_W-1:0] AD_START = ADDR_W'(A_START);
   localparam logic [ADDR_W-1:0] AD_STOP  = ADDR_W'(A_STOP);

   assign start_cmd = bus_rd && (bus_addr == AD_START);
   assign stop_cmd  = bus_rd && (bus_addr == AD_STOP);
   assign cfg_wr    = bus_wr && (bus_addr == AD_CFG);
endmodule

// File: rtl/pit_preload.sv
`timescale 1ns/1ps
module pit_preload #(
   parameter int              DATA_W   = 8,
   parameter int              CNT_W    = 16,
   parameter int              ADDR_W   = 4,
   parameter int              A_PRE_LO = 5,
   parameter logic [CNT_W-1:0] PRE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [CNT_W-1:0]  preload
);
   localparam int NBYTES = CNT_W / DATA_W;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(A_PRE_LO - i);
      always_ff @(posedge clk) begin
         if (!rst_n)
            preload[i*DATA_W +: DATA_W] <= PRE_RST[i*DATA_W +: DATA_W];
         else if (bus_wr && bus_addr == LANE_ADDR)
            preload[i*DATA_W +: DATA_W] <= bus_wdata;
      end
   end
endmodule

// File: rtl/pit_core.sv
`timescale 1ns/1ps
module pit_core
   import pit_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] CNT_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start_cmd,
   input  logic             stop_cmd,
   input  logic             cfg_wr,
   input  pit_cfg_t         cfg_in,
   input  logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] count,
   output pit_cfg_t         cfg_q,
   output logic             sq_out,
   output logic             ready
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic running;
   logic is_timer;
   logic halt_now;
   logic advance;
   logic at_term;

   assign is_timer = (cfg_q.mode == MODE_TIMER);
   assign halt_now = stop_cmd && !is_timer;
   assign advance  = running && tick && !start_cmd && !halt_now;
   assign at_term  = is_timer ? (count <= ONE) : (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cfg_q   <= '{irq_en: 1'b0, mode: MODE_TIMER};
         count   <= CNT_RST;
         sq_out  <= 1'b0;
      end else begin
         if (cfg_wr && !running)
            cfg_q <= cfg_in;
         if (start_cmd) begin
            running <= 1'b1;
            count   <= preload;
         end else begin
            if (halt_now)
               running <= 1'b0;
            if (advance) begin
               if (is_timer && at_term) begin
                  count  <= preload;
                  sq_out <= ~sq_out;
               end else begin
                  count <= count - ONE;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ready <= 1'b0;
      else if (stop_cmd)
         ready <= 1'b0;
      else if (advance && at_term)
         ready <= 1'b1;
   end

   // R5: a running timer stays running
   a_r5_timer_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (running && is_timer) |=> running);
   // R1: a stopped block only changes its count through a start
   a_r1_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_cmd) |=> $stable(count));
   // R3: start loads the preload
   a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start_cmd |=> (count == $past(preload)));
   // R8: configuration is frozen while running
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> $stable(cfg_q));
   // R7: stop clears the flag
   a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> !ready);
   // R4 / R6: the square wave moves only in a running timer
   a_r4_sq_timer_only: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_out != $past(sq_out)) |-> ($past(running) && $past(is_timer)));
endmodule

// File: rtl/pit_readback.sv
`timescale 1ns/1ps
module pit_readback
   import pit_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 4,
   parameter int A_CFG    = 2,
   parameter int A_CNT_LO = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  count,
   input  pit_cfg_t          cfg_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int NBYTES = CNT_W / DATA_W;
   localparam logic [ADDR_W-1:0] AD_LO  = ADDR_W'(A_CNT_LO);
   localparam logic [ADDR_W-1:0] AD_CFG = ADDR_W'(A_CFG);

   logic [CNT_W-1:DATA_W] hold_q;
   logic [NBYTES-1:0]     lane_hit;
   logic [DATA_W-1:0]     lane_val [NBYTES];

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '1;
      else if (bus_rd && bus_addr == AD_LO)
         hold_q <= count[CNT_W-1:DATA_W];
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(A_CNT_LO - i);
      assign lane_hit[i] = (bus_addr == LANE_ADDR);
      if (i == 0) begin : g_live
         assign lane_val[i] = count[DATA_W-1:0];
      end else begin : g_held
         assign lane_val[i] = hold_q[i*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NBYTES; i++)
         if (lane_hit[i]) bus_rdata = lane_val[i];
      if (bus_addr == AD_CFG)
         bus_rdata = {{(DATA_W-2){1'b0}}, cfg_q.irq_en, cfg_q.mode};
   end

   // R10: the upper byte shown equals the count captured at the last low read
   a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AD_LO) |=> (hold_q == $past(count[CNT_W-1:DATA_W])));
endmodule

// File: rtl/prog_interval_timer.sv
`timescale 1ns/1ps
module prog_interval_timer
   import pit_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 4,
   parameter int A_CFG    = 2,
   parameter int A_PRE_LO = 5,
   parameter int A_CNT_LO = 7,
   parameter int A_START  = 14,
   parameter int A_STOP   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sq_out,
   output logic              ready,
   output logic              irq
);
   localparam int               NBYTES  = CNT_W / DATA_W;
   localparam logic [CNT_W-1:0] CNT_RST = '1;

   if (CNT_W % DATA_W != 0) begin : g_bad_split
      $error("count width must be a whole number of bytes");
   end
   if (NBYTES < 2 || DATA_W < 2) begin : g_bad_lanes
      $error("need at least two lanes of at least two bits");
   end
   if (A_PRE_LO < NBYTES - 1 || A_CNT_LO < NBYTES - 1) begin : g_bad_base
      $error("lane addresses fall below zero");
   end
   if (A_STOP >= (1 << ADDR_W) || A_START >= (1 << ADDR_W)) begin : g_bad_addr
      $error("command address does not fit the address width");
   end

   logic             start_cmd, stop_cmd, cfg_wr;
   logic [CNT_W-1:0] preload, count;
   pit_cfg_t         cfg_in, cfg_q;
   logic             unused_wdata_hi;

   assign cfg_in          = '{irq_en: bus_wdata[1], mode: pit_mode_e'(bus_wdata[0])};
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

   pit_cmd_decode #(
      .ADDR_W(ADDR_W), .A_CFG(A_CFG), .A_START(A_START), .A_STOP(A_STOP)
   ) u_dec (
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .cfg_wr(cfg_wr)
   );

   pit_preload #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .A_PRE_LO(A_PRE_LO), .PRE_RST(CNT_RST)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .preload(preload)
   );

   pit_core #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .cfg_wr(cfg_wr),
      .cfg_in(cfg_in), .preload(preload), .count(count), .cfg_q(cfg_q),
      .sq_out(sq_out), .ready(ready)
   );

   pit_readback #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .A_CFG(A_CFG), .A_CNT_LO(A_CNT_LO)
   ) u_rb (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .count(count), .cfg_q(cfg_q), .bus_rdata(bus_rdata)
   );

   assign irq = ready && cfg_q.irq_en;

   // R9: the interrupt follows the flag only when enabled
   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cfg_q.irq_en) |-> irq);
endmodule

// File: tb/prog_interval_timer_bench.sv
`timescale 1ns/1ps
module prog_interval_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       sq_out, ready, irq;
   int         n_checks = 0;
   int         n_errors = 0;
   logic [7:0] d;

   prog_interval_timer u_prog_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sq_out(sq_out), .ready(ready), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   task automatic do_ticks(input int n);
      @(negedge clk) tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 sq_out", {15'd0, sq_out}, 16'd0);
      chk("R1 ready", {15'd0, ready}, 16'd0);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      rd(4'h2, d); chk("R1 cfg", {8'd0, d}, 16'h00);
      rd(4'h7, d); chk("R1 count lo", {8'd0, d}, 16'hFF);
      rd(4'h6, d); chk("R1 count hi", {8'd0, d}, 16'hFF);
      do_ticks(5);
      rd(4'h7, d); chk("R1 stopped ignores ticks", {8'd0, d}, 16'hFF);
   endtask

   task automatic t_timer_wave();
      wr(4'h4, 8'h00);
      wr(4'h5, 8'h04);
      rd(4'hE, d);
      rd(4'h7, d); chk("R2/R3 start loads preload", {8'd0, d}, 16'h04);
      do_ticks(3);
      chk("R4 no toggle before terminal", {15'd0, sq_out}, 16'd0);
      rd(4'h7, d); chk("R4 decrement", {8'd0, d}, 16'h01);
      do_ticks(1);
      chk("R4 toggle at terminal", {15'd0, sq_out}, 16'd1);
      chk("R4 ready set", {15'd0, ready}, 16'd1);
      chk("R9 irq masked", {15'd0, irq}, 16'd0);
      rd(4'h7, d); chk("R4 reload", {8'd0, d}, 16'h04);
      do_ticks(4);
      chk("R4 half period", {15'd0, sq_out}, 16'd0);
   endtask

   task automatic t_timer_no_stop();
      rd(4'hF, d);
      chk("R7 stop clears ready", {15'd0, ready}, 16'd0);
      do_ticks(2);
      rd(4'h7, d); chk("R5 timer ignores stop", {8'd0, d}, 16'h02);
      wr(4'h2, 8'h03);
      rd(4'h2, d); chk("R8 cfg ignored while running", {8'd0, d}, 16'h00);
      do_ticks(2);
      chk("R5 wave continues", {15'd0, sq_out}, 16'd1);
      do_ticks(2);
      rd(4'hE, d);
      rd(4'h7, d); chk("R3 restart reloads", {8'd0, d}, 16'h04);
   endtask

   task automatic t_counter();
      do_reset();
      wr(4'h2, 8'h03);
      rd(4'h2, d); chk("R2 cfg readback", {8'd0, d}, 16'h03);
      wr(4'h4, 8'h00);
      wr(4'h5, 8'h03);
      tick = 1'b1;
      rd(4'hE, d);
      tick = 1'b0;
      rd(4'h7, d); chk("R3 start beats tick", {8'd0, d}, 16'h03);
      do_ticks(2);
      rd(4'h7, d); chk("R6 decrement", {8'd0, d}, 16'h01);
      chk("R6 no ready yet", {15'd0, ready}, 16'd0);
      do_ticks(1);
      chk("R6 ready at zero", {15'd0, ready}, 16'd1);
      chk("R9 irq enabled", {15'd0, irq}, 16'd1);
      chk("R6 sq steady", {15'd0, sq_out}, 16'd0);
      rd(4'h7, d); chk("R6 reaches zero", {8'd0, d}, 16'h00);
      do_ticks(1);
      rd(4'h7, d); chk("R6 wrap lo", {8'd0, d}, 16'hFF);
      rd(4'h6, d); chk("R6 wrap hi", {8'd0, d}, 16'hFF);
      rd(4'hF, d);
      chk("R7 stop clears ready", {15'd0, ready}, 16'd0);
      chk("R9 irq drops", {15'd0, irq}, 16'd0);
      do_ticks(3);
      rd(4'h7, d); chk("R6 stop halts", {8'd0, d}, 16'hFF);
      wr(4'h2, 8'h01);
      rd(4'h2, d); chk("R8 cfg accepted when stopped", {8'd0, d}, 16'h01);
   endtask

   task automatic t_latch();
      wr(4'h4, 8'h01);
      wr(4'h5, 8'h00);
      rd(4'hE, d);
      rd(4'h7, d); chk("R10 lo live", {8'd0, d}, 16'h00);
      do_ticks(1);
      rd(4'h6, d); chk("R10 hi captured", {8'd0, d}, 16'h01);
      rd(4'h7, d); chk("R10 lo after tick", {8'd0, d}, 16'hFF);
      rd(4'h6, d); chk("R10 hi recaptured", {8'd0, d}, 16'h00);
      rd(4'h9, d); chk("R10 unmapped", {8'd0, d}, 16'h00);
   endtask

   initial begin
      t_reset_state();
      t_timer_wave();
      t_timer_no_stop();
      t_counter();
      t_latch();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #200000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule